// File: doc/BRIEF.md
# Accumulator Processor Control Sequencer

This block is the hardwired sequencer that steers the datapath of a small multi-cycle accumulator processor. It is a finite state machine with fourteen states held in a 4-bit register. The datapath supplies two inputs: the opcode field of the instruction that has been fetched, and the sign bit of the accumulator. From these the sequencer drives every control point of the datapath. These are the ALU function, the memory bus command, the program-counter update and its enable, the address-out register source and its enable, the data-in, accumulator and data-bus-drive controls.

Each instruction starts with one fetch step. The sequencer then runs a short execute path of one to three steps and comes back to fetch. Every path keeps one rule on return: the address register already holds the address of the next instruction, and the program counter already points one instruction (2 bytes) past it. The sequencer ignores the indirect bit, because it supports direct operands only.

Top module: `acc_seq_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes reset1. Reset1 drives `pc_load`=1 and `pc_sel`=01 (clear), with every other enable 0. The next step, reset2, drives `ao_load`=1, `ao_sel`=0 (from PC), `pc_load`=1 and `pc_sel`=10 (PC+2). Fetch follows reset2.
- R2: Fetch drives `bus_op`=01 (read) and `di_load`=1, with all other enables 0. The next state depends on opcode bits [2:0]: 11x goes to the arithmetic step, 00x to the single-operand step, 101 to load, 100 to store, 010 to branch-if-negative and 011 to jump.
- R3: Opcode bits above bit 2 have no effect on sequencing or on ALU selection.
- R4: The arithmetic step drives `alu_op` 011 (add) when opcode bit 0 is 1 and 010 (and) when it is 0. The single-operand step drives 100 (shift right) when opcode bit 0 is 1 and 001 (invert) when it is 0. Both steps set `acc_load`=1, restore the fetch rule and return to fetch.
- R5: Load has three steps. The first sets `ao_load`=1 with `ao_sel`=1 (operand address). The second reads memory (`bus_op`=01, `di_load`=1). The third drives `alu_op`=000 (pass) and `acc_load`=1, restores the fetch rule and returns to fetch.
- R6: Store has three steps. The first loads the operand address. The second drives `bus_op`=10 (write) with `edb_sel`=1. The third restores the fetch rule and returns to fetch.
- R7: Branch-if-negative first restores the fetch rule. If `acc_sign` is 1 in that step, a second step drives `ao_load`=1, `ao_sel`=1, `pc_load`=1 and `pc_sel`=11 (target+2). Otherwise control goes straight back to fetch.
- R8: Jump is one step, with the same outputs as the taken-branch step, followed by fetch.
- R9: Only fetch, the load read step and the store write step use the bus. The code 11 is never driven, and no step that loads the accumulator uses the bus.
- R10: Every bus read and every bus write comes directly after a step that loaded the address register. Every step that loads the accumulator also sets `pc_load`=1 with `pc_sel`=10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OPC_W (5) | Opcode field of the fetched instruction |
| acc_sign | input | 1 | Accumulator bit 15 (sign) |
| alu_op | output | 3 | ALU function: 000 pass, 001 invert, 010 and, 011 add, 100 shift right |
| bus_op | output | 2 | Memory command: 00 idle, 01 read, 10 write |
| pc_sel | output | 2 | PC source: 01 zero, 10 PC+2, 11 target+2 |
| pc_load | output | 1 | PC load enable |
| ao_sel | output | 1 | Address register source: 0 PC, 1 instruction address field |
| ao_load | output | 1 | Address register load enable |
| di_load | output | 1 | Data-in register load enable |
| acc_load | output | 1 | Accumulator load enable |
| edb_sel | output | 1 | Drive accumulator onto the data bus |

## Verification
Random opcodes change every cycle, together with a random sign bit and rare resets in mid-instruction. This shows that the next state depends only on the opcode bits sampled in fetch and on the sign bit sampled in the first branch step. Directed cases run the reset sequence, each instruction class, and the branch with the sign set and clear, which separates the taken path from the not-taken path. Opcodes with the upper bits set show that those bits change nothing. Because the fetch step and the load read step drive the same outputs, the steps that follow each one tell them apart.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

   localparam int ST_W  = 4;
   localparam int ALU_W = 3;
   localparam int BUS_W = 2;
   localparam int PCS_W = 2;
   localparam int KEY_W = 3;

   typedef enum logic [ST_W-1:0] {
      S_RST1  = 4'd0,
      S_RST2  = 4'd1,
      S_FETCH = 4'd2,
      S_AOPR  = 4'd3,
      S_SOPR  = 4'd4,
      S_STO1  = 4'd5,
      S_STO2  = 4'd6,
      S_STO3  = 4'd7,
      S_LD1   = 4'd8,
      S_LD2   = 4'd9,
      S_LD3   = 4'd10,
      S_BRN1  = 4'd11,
      S_BRN2  = 4'd12,
      S_JMP   = 4'd13
   } seq_state_t;

   localparam logic [ALU_W-1:0] ALU_PASS = 3'b000;
   localparam logic [ALU_W-1:0] ALU_INV  = 3'b001;
   localparam logic [ALU_W-1:0] ALU_AND  = 3'b010;
   localparam logic [ALU_W-1:0] ALU_ADD  = 3'b011;
   localparam logic [ALU_W-1:0] ALU_SHR  = 3'b100;

   localparam logic [BUS_W-1:0] BUS_IDLE = 2'b00;
   localparam logic [BUS_W-1:0] BUS_RD   = 2'b01;
   localparam logic [BUS_W-1:0] BUS_WR   = 2'b10;

   localparam logic [PCS_W-1:0] PCS_NONE = 2'b00;
   localparam logic [PCS_W-1:0] PCS_ZERO = 2'b01;
   localparam logic [PCS_W-1:0] PCS_INC  = 2'b10;
   localparam logic [PCS_W-1:0] PCS_TGT  = 2'b11;

   typedef struct packed {
      logic [ALU_W-1:0] alu;
      logic [BUS_W-1:0] bus;
      logic [PCS_W-1:0] pcs;
      logic             pc_ld;
      logic             ao_src;
      logic             ao_ld;
      logic             di_ld;
      logic             acc_ld;
      logic             edb;
   } ctrl_pts_t;

endpackage

// File: rtl/acc_seq_state_reg.sv
module acc_seq_state_reg
   import acc_seq_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  logic [ST_W-1:0] nxt,
   output logic [ST_W-1:0] cur
);

   always_ff @(posedge clk) begin
      if (rst) cur <= S_RST1;
      else     cur <= nxt;
   end

endmodule

// File: rtl/acc_seq_next.sv
module acc_seq_next
   import acc_seq_pkg::*;
(
   input  logic [ST_W-1:0]  cur,
   input  logic [KEY_W-1:0] key,
   input  logic             neg,
   output logic [ST_W-1:0]  nxt
);

   logic [ST_W-1:0] dispatch;

   always_comb begin
      case (key)
         3'b110, 3'b111: dispatch = S_AOPR;
         3'b000, 3'b001: dispatch = S_SOPR;
         3'b101:         dispatch = S_LD1;
         3'b100:         dispatch = S_STO1;
         3'b010:         dispatch = S_BRN1;
         default:        dispatch = S_JMP;
      endcase
   end

   always_comb begin
      case (cur)
         S_RST1:  nxt = S_RST2;
         S_RST2:  nxt = S_FETCH;
         S_FETCH: nxt = dispatch;
         S_LD1:   nxt = S_LD2;
         S_LD2:   nxt = S_LD3;
         S_STO1:  nxt = S_STO2;
         S_STO2:  nxt = S_STO3;
         S_BRN1:  nxt = neg ? S_BRN2 : S_FETCH;
         S_AOPR, S_SOPR, S_LD3, S_STO3, S_BRN2, S_JMP:
                  nxt = S_FETCH;
         default: nxt = S_RST1;
      endcase
   end

endmodule

// File: rtl/acc_seq_ctrl_dec.sv
module acc_seq_ctrl_dec
   import acc_seq_pkg::*;
(
   input  logic [ST_W-1:0]  cur,
   input  logic [KEY_W-1:0] key,
   output ctrl_pts_t        pts
);

   always_comb begin
      pts = '{alu: ALU_PASS, bus: BUS_IDLE, pcs: PCS_NONE, default: 1'b0};
      case (cur)
         S_RST1: begin
            pts.pc_ld = 1'b1;
            pts.pcs   = PCS_ZERO;
         end
         S_RST2, S_STO3, S_BRN1: begin
            pts.ao_ld = 1'b1;
            pts.pc_ld = 1'b1;
            pts.pcs   = PCS_INC;
         end
         S_FETCH, S_LD2: begin
            pts.bus   = BUS_RD;
            pts.di_ld = 1'b1;
         end
         S_AOPR: begin
            pts.alu    = key[0] ? ALU_ADD : ALU_AND;
            pts.acc_ld = 1'b1;
            pts.ao_ld  = 1'b1;
            pts.pc_ld  = 1'b1;
            pts.pcs    = PCS_INC;
         end
         S_SOPR: begin
            pts.alu    = key[0] ? ALU_SHR : ALU_INV;
            pts.acc_ld = 1'b1;
            pts.ao_ld  = 1'b1;
            pts.pc_ld  = 1'b1;
            pts.pcs    = PCS_INC;
         end
         S_LD3: begin
            pts.alu    = ALU_PASS;
            pts.acc_ld = 1'b1;
            pts.ao_ld  = 1'b1;
            pts.pc_ld  = 1'b1;
            pts.pcs    = PCS_INC;
         end
         S_LD1, S_STO1: begin
            pts.ao_ld  = 1'b1;
            pts.ao_src = 1'b1;
         end
         S_STO2: begin
            pts.bus = BUS_WR;
            pts.edb = 1'b1;
         end
         S_BRN2, S_JMP: begin
            pts.ao_ld  = 1'b1;
            pts.ao_src = 1'b1;
            pts.pc_ld  = 1'b1;
            pts.pcs    = PCS_TGT;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
   import acc_seq_pkg::*;
#(
   parameter int OPC_W = 5
)(
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opcode,
   input  logic             acc_sign,
   output logic [2:0]       alu_op,
   output logic [1:0]       bus_op,
   output logic [1:0]       pc_sel,
   output logic             pc_load,
   output logic             ao_sel,
   output logic             ao_load,
   output logic             di_load,
   output logic             acc_load,
   output logic             edb_sel
);

   localparam int UPPER_W = OPC_W - KEY_W;

   generate
      if (OPC_W < KEY_W) begin : g_bad_opc
         $error("acc_seq_ctrl: OPC_W must be at least %0d", KEY_W);
      end
      if (UPPER_W > 16) begin : g_wide_opc
         $error("acc_seq_ctrl: OPC_W above %0d is not supported", KEY_W + 16);
      end
   endgenerate

   logic [ST_W-1:0]  st_cur;
   logic [ST_W-1:0]  st_nxt;
   logic [KEY_W-1:0] key;
   ctrl_pts_t        pts;

   assign key = opcode[KEY_W-1:0];

   acc_seq_state_reg u_reg (
      .clk (clk),
      .rst (rst),
      .nxt (st_nxt),
      .cur (st_cur)
   );

   acc_seq_next u_next (
      .cur (st_cur),
      .key (key),
      .neg (acc_sign),
      .nxt (st_nxt)
   );

   acc_seq_ctrl_dec u_dec (
      .cur (st_cur),
      .key (key),
      .pts (pts)
   );

   assign alu_op   = pts.alu;
   assign bus_op   = pts.bus;
   assign pc_sel   = pts.pcs;
   assign pc_load  = pts.pc_ld;
   assign ao_sel   = pts.ao_src;
   assign ao_load  = pts.ao_ld;
   assign di_load  = pts.di_ld;
   assign acc_load = pts.acc_ld;
   assign edb_sel  = pts.edb;

endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk (
   input logic       clk,
   input logic       rst,
   input logic [2:0] alu_op,
   input logic [1:0] bus_op,
   input logic [1:0] pc_sel,
   input logic       pc_load,
   input logic       ao_sel,
   input logic       ao_load,
   input logic       di_load,
   input logic       acc_load,
   input logic       edb_sel
);

   // R1: the first step after reset clears the PC
   p_reset_clears_pc_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (pc_load && pc_sel == 2'b01 && !ao_load && bus_op == 2'b00));

   // R6: a write drives the accumulator and loads nothing
   p_write_drives_acc_r6: assert property (@(posedge clk) disable iff (rst)
      (bus_op == 2'b10) |-> (edb_sel && !di_load && !acc_load && !pc_load));

   // R9: bus code 11 is never issued
   p_no_bad_bus_code_r9: assert property (@(posedge clk) disable iff (rst)
      bus_op != 2'b11);

   // R9: accumulator loads never share a step with a bus cycle
   p_acc_no_bus_r9: assert property (@(posedge clk) disable iff (rst)
      acc_load |-> (bus_op == 2'b00));

   // R10: a bus cycle follows an address register load
   p_bus_after_addr_r10: assert property (@(posedge clk) disable iff (rst)
      (bus_op != 2'b00) |-> $past(ao_load));

   // R10: accumulator loads also restore the fetch rule
   p_acc_restores_r10: assert property (@(posedge clk) disable iff (rst)
      acc_load |-> (pc_load && pc_sel == 2'b10 && ao_load && !ao_sel));

   // R7: a target load is never followed by another target load
   p_target_once_r7: assert property (@(posedge clk) disable iff (rst)
      (pc_sel == 2'b11) |=> (bus_op == 2'b01));

endmodule

bind acc_seq_ctrl acc_seq_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .alu_op   (alu_op),
   .bus_op   (bus_op),
   .pc_sel   (pc_sel),
   .pc_load  (pc_load),
   .ao_sel   (ao_sel),
   .ao_load  (ao_load),
   .di_load  (di_load),
   .acc_load (acc_load),
   .edb_sel  (edb_sel)
);

// File: tb/sim_acc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_acc_seq_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] opcode = 5'd0;
   logic       acc_sign = 1'b0;
   logic [2:0] alu_op;
   logic [1:0] bus_op;
   logic [1:0] pc_sel;
   logic       pc_load, ao_sel, ao_load, di_load, acc_load, edb_sel;

   int total = 0;
   int bad   = 0;
   int est   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   acc_seq_ctrl #(.OPC_W(5)) u0 (
      .clk(clk), .rst(rst), .opcode(opcode), .acc_sign(acc_sign),
      .alu_op(alu_op), .bus_op(bus_op), .pc_sel(pc_sel), .pc_load(pc_load),
      .ao_sel(ao_sel), .ao_load(ao_load), .di_load(di_load),
      .acc_load(acc_load), .edb_sel(edb_sel)
   );

   // packing: alu[12:10] bus[9:8] pcsel[7:6] pcld ao_sel ao_ld di_ld acc_ld edb
   function automatic logic [12:0] mk(logic [2:0] a, logic [1:0] b, logic [1:0] p,
                                      logic pl, logic as, logic al, logic dl,
                                      logic cl, logic e);
      return {a, b, p, pl, as, al, dl, cl, e};
   endfunction

   function automatic logic [12:0] model_out(int st, logic [4:0] o);
      case (st)
         0:        return mk(3'b000, 2'b00, 2'b01, 1, 0, 0, 0, 0, 0);
         1, 7, 11: return mk(3'b000, 2'b00, 2'b10, 1, 0, 1, 0, 0, 0);
         2, 9:     return mk(3'b000, 2'b01, 2'b00, 0, 0, 0, 1, 0, 0);
         3:        return mk(o[0] ? 3'b011 : 3'b010, 2'b00, 2'b10, 1, 0, 1, 0, 1, 0);
         4:        return mk(o[0] ? 3'b100 : 3'b001, 2'b00, 2'b10, 1, 0, 1, 0, 1, 0);
         10:       return mk(3'b000, 2'b00, 2'b10, 1, 0, 1, 0, 1, 0);
         5, 8:     return mk(3'b000, 2'b00, 2'b00, 0, 1, 1, 0, 0, 0);
         6:        return mk(3'b000, 2'b10, 2'b00, 0, 0, 0, 0, 0, 1);
         default:  return mk(3'b000, 2'b00, 2'b11, 1, 1, 1, 0, 0, 0);
      endcase
   endfunction

   function automatic int model_next(int st, logic [4:0] o, logic s);
      case (st)
         0: return 1;
         1: return 2;
         2: case (o[2:0])
               3'b110, 3'b111: return 3;
               3'b000, 3'b001: return 4;
               3'b101:         return 8;
               3'b100:         return 5;
               3'b010:         return 11;
               default:        return 13;
            endcase
         5: return 6;
         6: return 7;
         8: return 9;
         9: return 10;
         11: return s ? 12 : 2;
         default: return 2;
      endcase
   endfunction

   function automatic string state_tag(int st);
      case (st)
         0, 1:       return "R1";
         2:          return "R2";
         3, 4:       return "R4";
         5, 6, 7:    return "R6";
         8, 9, 10:   return "R5";
         11, 12:     return "R7";
         default:    return "R8";
      endcase
   endfunction

   task automatic step(input logic r, input logic [4:0] o, input logic s, input string tag);
      logic [12:0] got, exp;
      @(negedge clk);
      rst = r; opcode = o; acc_sign = s;
      #1;
      got = {alu_op, bus_op, pc_sel, pc_load, ao_sel, ao_load, di_load, acc_load, edb_sel};
      exp = model_out(est, o);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s state=%0d got=%b exp=%b", (tag == "") ? state_tag(est) : tag,
                  est, got, exp);
      end
      est = r ? 0 : model_next(est, o, s);
   endtask

   initial begin
      void'($urandom(32'd4036));
      repeat (2) @(posedge clk);
      est = 0;
      // R1: reset held, then release through reset2 into fetch
      step(1, 5'b00000, 0, "R1");
      step(0, 5'b00000, 0, "R1");
      step(0, 5'b00000, 0, "R1");
      // R2: fetch, dispatch to aopr add (R4)
      step(0, 5'b00111, 0, "R2");
      step(0, 5'b00111, 0, "R4");
      // R3: upper bits set, key 101 -> load
      step(0, 5'b11101, 0, "R2");
      step(0, 5'b10101, 0, "R3");
      step(0, 5'b01000, 0, "R5");
      step(0, 5'b11000, 0, "R5");
      // R7: branch taken
      step(0, 5'b00010, 0, "R2");
      step(0, 5'b00010, 1, "R7");
      step(0, 5'b00010, 0, "R7");
      // R7: branch not taken
      step(0, 5'b00010, 0, "R2");
      step(0, 5'b00010, 0, "R7");
      step(0, 5'b00100, 0, "R7");
      // R6: store
      step(0, 5'b00100, 0, "R6");
      step(0, 5'b00100, 0, "R6");
      step(0, 5'b00100, 0, "R6");
      // R8: jump with upper bits set (R3)
      step(0, 5'b01011, 0, "R2");
      step(0, 5'b01011, 0, "R3");
      // R4: single-operand shift and invert
      step(0, 5'b00001, 0, "R2");
      step(0, 5'b00001, 0, "R4");
      step(0, 5'b00000, 0, "R2");
      step(0, 5'b00000, 0, "R4");
      // random mix with rare mid-instruction resets
      for (int i = 0; i < 3000; i++) begin
         logic [4:0] o;
         logic r, s;
         o = 5'($urandom);
         s = 1'($urandom);
         r = ($urandom % 97) == 0;
         step(r, o, s, "");
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 200000; c++) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule